// File: doc/BRIEF.md
# Eight-Function 32-bit ALU

This block is a purely combinational arithmetic logic unit for a small datapath. Two operands, `opa_i` and `opb_i`, and a four-bit function select enter, and a result word plus a zero flag leave in the same cycle. The result is whatever the select asks for. The logic group gives bitwise AND, OR, XOR and NOR. The arithmetic group gives two's-complement addition and subtraction. The compare gives a signed less-than that yields a 0/1 word. The shift moves `opb_i` left by a distance taken from `opa_i`.

The upper half of the select space is held back for later functions and produces an all-zero result. No state is kept, so the block has no clock and no reset. A surrounding register stage, such as a register file write port, captures the result on its own clock. Operand width is a parameter. The shift distance field and the internal shifter stages are derived from that width.

Top module: `opsel_alu`

## Requirements
- R1: Select 4'h0 gives opa AND opb, 4'h1 gives opa OR opb, 4'h2 gives opa XOR opb, and 4'h3 gives the bitwise inverse of (opa OR opb).
- R2: Select 4'h4 gives opa + opb modulo 2^32, with any carry out of bit 31 dropped.
- R3: Select 4'h5 gives opa − opb modulo 2^32 in two's complement.
- R4: Select 4'h6 gives 32'd1 when opa is less than opb, both read as signed two's-complement numbers, and 32'd0 otherwise. This includes operands of opposite sign whose difference overflows.
- R5: Select 4'h7 gives opb shifted left logically by opa[4:0], filling with zeros. Bits opa[31:5] have no effect on the result.
- R6: Selects 4'h8 through 4'hF give a result of 32'd0 whatever the operands.
- R7: The zero flag is 1 exactly when the 32-bit result equals zero, for every select value.
- R8: Result and zero flag depend only on the current inputs, with no clock cycle of latency.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand; also supplies the shift distance in its low bits |
| opb_i | input | 32 | Second operand; the value shifted by the shift function |
| fsel_i | input | 4 | Function select |
| res_o | output | 32 | Result word |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
The bench builds the block with its default width of 32. With that width the shift distance field is five bits wide. This makes both boundary distances (0 and 31) and the discarded upper bits of `opa_i` reachable with simple operand values. Operands near the most positive and most negative 32-bit values exercise the carry wrap in addition. They also drive the compare into the overflow case, where the sign of the raw difference would give the wrong answer. Every reserved select is swept with all-ones and mixed operands, so that any leak of a defined function into the reserved space shows in the result.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  localparam int unsigned FSEL_W = 4;

  typedef enum logic [FSEL_W-1:0] {
    FN_AND  = 4'h0,
    FN_OR   = 4'h1,
    FN_XOR  = 4'h2,
    FN_NOR  = 4'h3,
    FN_ADD  = 4'h4,
    FN_SUB  = 4'h5,
    FN_SLT  = 4'h6,
    FN_SHL  = 4'h7
  } alu_fn_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]              a_i,
  input  logic [WIDTH-1:0]              b_i,
  input  opsel_alu_pkg::logic_fn_e      fn_i,
  output logic [WIDTH-1:0]              y_o
);
  import opsel_alu_pkg::*;

  logic [WIDTH-1:0] or_w;
  assign or_w = a_i | b_i;

  // R1: the four bitwise functions
  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = or_w;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~or_w;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             slt_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  // R2, R3: one adder shared by add and subtract
  assign b_eff = b_i ^ {WIDTH{sub_i}};
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o = full[WIDTH-1:0];

  // R4: signed less-than, valid when sub_i is set
  always_comb begin
    if (a_i[MSB] != b_i[MSB]) slt_o = a_i[MSB];
    else                      slt_o = full[MSB];
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [SHW-1:0]   amt_i,
  output logic [WIDTH-1:0] y_o
);
  logic [WIDTH-1:0] stage [SHW+1];

  assign stage[0] = val_i;

  // R5: logarithmic left shifter, one stage per distance bit
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int unsigned DIST = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][WIDTH-1-DIST:0], {DIST{1'b0}}}
                                 : stage[s];
  end

  assign y_o = stage[SHW];
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [3:0]       fsel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o
);
  import opsel_alu_pkg::*;

  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] sum_y;
  logic [WIDTH-1:0] shl_y;
  logic             lt_y;
  logic_fn_e        lfn;

  assign lfn = logic_fn_e'(fsel_i[1:0]);

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .fn_i (lfn),
    .y_o  (logic_y)
  );

  // subtract for both FN_SUB and FN_SLT (select bit 0 or bit 1 set)
  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sub_i (fsel_i[0] | fsel_i[1]),
    .sum_o (sum_y),
    .slt_o (lt_y)
  );

  alu_shifter #(.WIDTH(WIDTH)) u_shl (
    .val_i (opb_i),
    .amt_i (opa_i[SHW-1:0]),
    .y_o   (shl_y)
  );

  // R6: reserved selects fall to zero; R8: no storage anywhere
  always_comb begin
    res_o = '0;
    if (!fsel_i[3]) begin
      case (fsel_i[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: res_o = logic_y;
        3'd4, 3'd5:             res_o = sum_y;
        3'd6:                   res_o = {{(WIDTH-1){1'b0}}, lt_y};
        default:                res_o = shl_y;
      endcase
    end
  end

  // R7
  assign zero_o = ~|res_o;
endmodule

// File: rtl/opsel_alu_checker.sv
module opsel_alu_checker #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [3:0]       fsel_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    p_nor_disjoint_r1: assert (fsel_i != 4'h3 || (res_o & (opa_i | opb_i)) == '0)
      else $error("R1 nor result overlaps operand bits");
    p_add_inverse_r2: assert (fsel_i != 4'h4 || res_o - opb_i == opa_i)
      else $error("R2 sum minus opb differs from opa");
    p_sub_inverse_r3: assert (fsel_i != 4'h5 || res_o + opb_i == opa_i)
      else $error("R3 difference plus opb differs from opa");
    p_slt_bool_r4: assert (fsel_i != 4'h6 || res_o[WIDTH-1:1] == '0)
      else $error("R4 compare result not 0 or 1");
    p_shl_lowfill_r5: assert (fsel_i != 4'h7 ||
                              (res_o & ((ONE << opa_i[SHW-1:0]) - ONE)) == '0)
      else $error("R5 shift left low bits not zero");
    p_reserved_zero_r6: assert (!fsel_i[3] || res_o == '0)
      else $error("R6 reserved select gave nonzero result");
    p_zero_flag_r7: assert (zero_o == (res_o == '0))
      else $error("R7 zero flag mismatch");
  end
endmodule

bind opsel_alu opsel_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .fsel_i (fsel_i),
  .res_o  (res_o),
  .zero_o (zero_o)
);

// File: tb/test_opsel_alu.sv
module test_opsel_alu;
  localparam int W  = 32;
  localparam int NV = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a, b;
  logic [3:0]   sel;
  logic [W-1:0] res;
  logic         zf;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  opsel_alu #(.WIDTH(W)) i_opsel_alu (
    .opa_i(a), .opb_i(b), .fsel_i(sel), .res_o(res), .zero_o(zf)
  );

  // entry = {sel, a, b, expected}
  localparam logic [99:0] VEC [NV] = '{
    {4'h0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000},  // R1 and
    {4'h1, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0},  // R1 or
    {4'h2, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0},  // R1 xor
    {4'h3, 32'hF0F0F0F0, 32'hFF00FF00, 32'h000F000F},  // R1 nor
    {4'h4, 32'h7FFFFFFF, 32'h00000001, 32'h80000000},  // R2
    {4'h4, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},  // R2 carry dropped
    {4'h5, 32'h00000005, 32'h00000007, 32'hFFFFFFFE},  // R3
    {4'h5, 32'h80000000, 32'h00000001, 32'h7FFFFFFF},  // R3
    {4'h6, 32'hFFFFFFFF, 32'h00000001, 32'h00000001},  // R4 -1 < 1
    {4'h6, 32'h00000001, 32'hFFFFFFFF, 32'h00000000},  // R4
    {4'h6, 32'h80000000, 32'h7FFFFFFF, 32'h00000001},  // R4 overflow case
    {4'h6, 32'h00000003, 32'h00000003, 32'h00000000},  // R4 equal
    {4'h7, 32'h00000004, 32'h0000000F, 32'h000000F0},  // R5
    {4'h7, 32'hFFFFFFE1, 32'h80000001, 32'h00000002},  // R5 upper bits ignored
    {4'h7, 32'h0000001F, 32'h00000003, 32'h80000000},  // R5 max distance
    {4'h7, 32'h00000020, 32'h12345678, 32'h12345678},  // R5 distance 0
    {4'h8, 32'h00000001, 32'h00000002, 32'h00000000},  // R6
    {4'hF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}   // R6
  };

  function automatic string req_of(input logic [3:0] s);
    if (s[3])        return "R6";
    if (s == 4'h7)   return "R5";
    if (s == 4'h6)   return "R4";
    if (s == 4'h5)   return "R3";
    if (s == 4'h4)   return "R2";
    return "R1";
  endfunction

  task automatic check(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (sel=%h a=%h b=%h)", rq, act, exp, sel, a, b);
    end
  endtask

  task automatic apply(input logic [3:0] s, input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    sel = s; a = x; b = y;
    @(negedge clk);
  endtask

  initial begin
    a = '0; b = '0; sel = 4'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // start state: all-zero inputs give zero result and zero flag set (R1, R7)
    check("R1", res, '0);
    check("R7", {31'd0, zf}, 32'd1);

    // R8: change inputs without any clock edge, output follows at once
    a = 32'h0000000A; b = 32'h00000003; sel = 4'h4;
    #0.5;
    check("R8", res, 32'h0000000D);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32]);
      check(req_of(VEC[i][99:96]), res, VEC[i][31:0]);
      check("R7", {31'd0, zf}, {31'd0, VEC[i][31:0] == '0});
    end

    // R5: every distance, with junk in the ignored upper bits of opa
    for (int k = 0; k < W; k++) begin
      apply(4'h7, {27'h5A5A5A5, 5'(k)}, 32'hC3A5_0F17);
      check("R5", res, 32'hC3A5_0F17 << k);
    end

    // R6: all reserved selects with nonzero operands
    for (int s = 8; s < 16; s++) begin
      apply(4'(s), 32'hDEADBEEF, 32'h01234567);
      check("R6", res, '0);
      check("R7", {31'd0, zf}, 32'd1);
    end

    // R3, R7: equal operands subtract to zero
    apply(4'h5, 32'h89ABCDEF, 32'h89ABCDEF);
    check("R3", res, '0);
    check("R7", {31'd0, zf}, 32'd1);

    // R4: positive vs negative, opposite order
    apply(4'h6, 32'h7FFFFFFF, 32'h80000000);
    check("R4", res, 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule